// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block decides what a host sees on the data bus while an internal word-program or whole-chip erase is running. It sits between the internal sequencer and the output data path. While an operation is active it replaces array data with a status word. That word holds a polling bit, a toggle bit and a timeout bit. The host can then tell an operation in progress from one that has finished or failed. When the operation ends, the block hands the bus back to the array read path unchanged.

The sequencer raises `seq_busy` for the length of an operation and gives the operation kind and bit 7 of the word being written at its start. The block counts busy cycles against a timeout limit of its own. An overrun is held as a failure until a reset command arrives. An erase aimed only at protected regions is signalled by a one-cycle `erase_void` pulse. It produces a fixed-length polling window with no array activity.

Top module: `opstat_reporter`

## Requirements
- R1: After a synchronous reset `polling_active` is 0 and `dout` equals `array_word`. The toggle bit starts from 0 at the beginning of every operation.
- R2: During a word program, bit 7 of `dout` is the inverse of `prog_poll_bit` as sampled in the cycle the operation started.
- R3: During a chip erase, whether it is running, timed out or protected-only, bit 7 of `dout` is 0.
- R4: While status is shown, bit 6 of `dout` inverts once for each rising edge of `rd_stb` and at no other time. The first read of an operation returns 1.
- R5: One cycle after `seq_busy` falls, with no timeout, `polling_active` is 0 and `dout` equals `array_word`. Later reads return array data.
- R6: If `seq_busy` stays high for `TIMEOUT_CYC` cycles after the start, bit 5 of `dout` becomes 1. Status stays on the bus after `seq_busy` falls, and polling and toggling keep working.
- R7: After a timeout, only a `rst_cmd` pulse returns the bus to array data. A new `seq_busy` is ignored until then.
- R8: A `rst_cmd` pulse while an operation is busy has no effect.
- R9: Asserting `rst` aborts any operation. On the next cycle the bus shows array data.
- R10: An `erase_void` pulse shows erase status for exactly `HOLD_CYC` cycles. After that the bus returns to array data.
- R11: While status is shown, bits 15:8 and 4:0 of `dout` are 0.
- R12: Changing `prog_poll_bit` after the program has started does not change the polling bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| seq_busy | input | 1 | Sequencer is running an operation |
| seq_erase | input | 1 | Operation kind at start: 1 erase, 0 program |
| prog_poll_bit | input | 1 | Bit 7 of the word being programmed |
| erase_void | input | 1 | Pulse: erase started on protected regions only |
| rst_cmd | input | 1 | Pulse: reset command decoded |
| rd_stb | input | 1 | Read strobe level, high during a read cycle |
| array_word | input | W | Data from the array read path |
| dout | output | W | Word driven to the host |
| polling_active | output | 1 | Status word is replacing array data |

## Verification
Random program and erase operations are run with random polled data, random read counts and a random array word. This shows whether the polling bit follows the operation kind and the datum latched at the start, and whether the toggle follows the read count. A directed overrun separates a sticky timeout from plain completion. It also shows that reset commands and new starts are ignored in that state. Directed tests cover a reset command during busy, a hardware abort and the protected-only erase window. These separate the three exit paths.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

    typedef enum logic [1:0] {
        ST_ARRAY = 2'd0,
        ST_BUSY  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_FAIL  = 2'd3
    } opst_e;

    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;
    localparam int TMO_BIT  = 5;

    typedef struct packed {
        logic erase;
        logic poll_src;
        logic tog;
        logic fail;
    } stat_fields_t;

    function automatic logic [15:0] pack_status(stat_fields_t f);
        logic [15:0] w;
        w = '0;
        w[POLL_BIT] = f.erase ? 1'b0 : ~f.poll_src;
        w[TOG_BIT]  = f.tog;
        w[TMO_BIT]  = f.fail;
        return w;
    endfunction

endpackage

// File: rtl/opstat_edge.sv
module opstat_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/opstat_tracker.sv
module opstat_tracker
    import opstat_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int HOLD_CYC    = 40
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  seq_busy,
    input  logic  seq_erase,
    input  logic  prog_poll_bit,
    input  logic  erase_void,
    input  logic  rst_cmd,
    input  logic  rd_rise,
    output opst_e state,
    output logic  kind_erase,
    output logic  poll_src,
    output logic  tog
);
    localparam int MAXC  = (TIMEOUT_CYC > HOLD_CYC) ? TIMEOUT_CYC : HOLD_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_ARRAY;
            kind_erase <= 1'b0;
            poll_src   <= 1'b0;
            tog        <= 1'b0;
            cnt        <= '0;
        end else begin
            if (state != ST_ARRAY && rd_rise)
                tog <= ~tog;
            case (state)
                ST_ARRAY: begin
                    if (seq_busy) begin
                        state      <= ST_BUSY;
                        kind_erase <= seq_erase;
                        poll_src   <= prog_poll_bit;
                        tog        <= 1'b0;
                        cnt        <= '0;
                    end else if (erase_void) begin
                        state      <= ST_HOLD;
                        kind_erase <= 1'b1;
                        tog        <= 1'b0;
                        cnt        <= '0;
                    end
                end
                ST_BUSY: begin
                    if (!seq_busy)            state <= ST_ARRAY;
                    else if (cnt == TMO_LAST) state <= ST_FAIL;
                    else                      cnt   <= cnt + 1'b1;
                end
                ST_HOLD: begin
                    if (cnt == HOLD_LAST) state <= ST_ARRAY;
                    else                  cnt   <= cnt + 1'b1;
                end
                ST_FAIL: begin
                    if (rst_cmd) state <= ST_ARRAY;
                end
                default: state <= ST_ARRAY;
            endcase
        end
    end
endmodule

// File: rtl/opstat_fmt.sv
module opstat_fmt
    import opstat_pkg::*;
#(
    parameter int W = 16
) (
    input  opst_e        state,
    input  logic         kind_erase,
    input  logic         poll_src,
    input  logic         tog,
    input  logic [W-1:0] array_word,
    output logic [W-1:0] dout,
    output logic         status_on
);
    stat_fields_t f;
    logic [15:0]  sw;

    always_comb begin
        f.erase    = kind_erase;
        f.poll_src = poll_src;
        f.tog      = tog;
        f.fail     = (state == ST_FAIL);
        sw         = pack_status(f);
        status_on  = (state != ST_ARRAY);
    end

    generate
        if (W > 16) begin : g_wide
            assign dout = status_on ? {{(W-16){1'b0}}, sw} : array_word;
        end else begin : g_narrow
            assign dout = status_on ? sw[W-1:0] : array_word;
        end
    endgenerate
endmodule

// File: rtl/opstat_reporter.sv
module opstat_reporter
    import opstat_pkg::*;
#(
    parameter int W           = 16,
    parameter int TIMEOUT_CYC = 64,
    parameter int HOLD_CYC    = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seq_busy,
    input  logic         seq_erase,
    input  logic         prog_poll_bit,
    input  logic         erase_void,
    input  logic         rst_cmd,
    input  logic         rd_stb,
    input  logic [W-1:0] array_word,
    output logic [W-1:0] dout,
    output logic         polling_active
);
    logic  rd_rise;
    opst_e state;
    logic  kind_erase;
    logic  poll_src;
    logic  tog;

    opstat_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (rd_stb),
        .rise   (rd_rise)
    );

    opstat_tracker #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .HOLD_CYC    (HOLD_CYC)
    ) u_trk (
        .clk           (clk),
        .rst           (rst),
        .seq_busy      (seq_busy),
        .seq_erase     (seq_erase),
        .prog_poll_bit (prog_poll_bit),
        .erase_void    (erase_void),
        .rst_cmd       (rst_cmd),
        .rd_rise       (rd_rise),
        .state         (state),
        .kind_erase    (kind_erase),
        .poll_src      (poll_src),
        .tog           (tog)
    );

    opstat_fmt #(.W(W)) u_fmt (
        .state      (state),
        .kind_erase (kind_erase),
        .poll_src   (poll_src),
        .tog        (tog),
        .array_word (array_word),
        .dout       (dout),
        .status_on  (polling_active)
    );
endmodule

// File: rtl/opstat_chk.sv
module opstat_chk
    import opstat_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         seq_busy,
    input logic         rst_cmd,
    input logic         rd_rise,
    input opst_e        state,
    input logic         kind_erase,
    input logic         tog,
    input logic         status_on,
    input logic [W-1:0] dout
);
    AST_RESET_TO_ARRAY: assert property (@(posedge clk)
        $past(rst) |-> !status_on);                                     // R9

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (rst)
        (status_on && kind_erase) |-> (dout[7] == 1'b0));               // R3

    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        status_on |-> (dout[4:0] == '0 && (dout >> 8) == '0));          // R11

    AST_TOG_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        ($past(state) != ST_ARRAY && state != ST_ARRAY && tog != $past(tog))
        |-> $past(rd_rise));                                            // R4

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_FAIL && !$past(rst_cmd) && !$past(rst))
        |-> state == ST_FAIL);                                          // R7

    AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_BUSY && $past(seq_busy) && !$past(rst))
        |-> state != ST_ARRAY);                                         // R8
endmodule

bind opstat_reporter opstat_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .seq_busy   (seq_busy),
    .rst_cmd    (rst_cmd),
    .rd_rise    (rd_rise),
    .state      (state),
    .kind_erase (kind_erase),
    .tog        (tog),
    .status_on  (polling_active),
    .dout       (dout)
);

// File: tb/opstat_reporter_tb_top.sv
module opstat_reporter_tb_top;
    localparam int W    = 16;
    localparam int TMO  = 64;
    localparam int HOLD = 40;

    logic         clk = 1'b0;
    logic         rst, seq_busy, seq_erase, prog_poll_bit, erase_void, rst_cmd, rd_stb;
    logic [W-1:0] array_word;
    logic [W-1:0] dout;
    logic         polling_active;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    opstat_reporter #(.W(W), .TIMEOUT_CYC(TMO), .HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst(rst), .seq_busy(seq_busy), .seq_erase(seq_erase),
        .prog_poll_bit(prog_poll_bit), .erase_void(erase_void), .rst_cmd(rst_cmd),
        .rd_stb(rd_stb), .array_word(array_word), .dout(dout),
        .polling_active(polling_active)
    );

    function automatic logic [W-1:0] exp_stat(bit erase, bit src, bit tg, bit fail);
        logic [W-1:0] w;
        w    = '0;
        w[7] = erase ? 1'b0 : ~src;
        w[6] = tg;
        w[5] = fail;
        return w;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
    endtask

    task automatic start_op(bit erase, bit src);
        seq_busy = 1'b1; seq_erase = erase; prog_poll_bit = src;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit tg;
        bit er, src;
        int nrd;
        void'($urandom(32'd1234));
        rst = 1'b1; seq_busy = 0; seq_erase = 0; prog_poll_bit = 0;
        erase_void = 0; rst_cmd = 0; rd_stb = 0; array_word = 16'h1234;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        chk("R1 reset dout", dout, 16'h1234);
        chk("R1 reset flag", {15'd0, polling_active}, 16'd0);

        // Random program/erase operations
        for (int it = 0; it < 24; it++) begin
            er  = 1'($urandom_range(0, 1));
            src = 1'($urandom_range(0, 1));
            nrd = $urandom_range(1, 8);
            array_word = 16'($urandom);
            start_op(er, src);
            prog_poll_bit = ~src;   // R12: later change must not matter
            tg = 0;
            chk(er ? "R3 erase poll" : "R2 program poll", dout, exp_stat(er, src, 1'b0, 1'b0));
            for (int r = 0; r < nrd; r++) begin
                do_read();
                tg = ~tg;
                chk("R4 toggle per read", dout, exp_stat(er, src, tg, 1'b0));
                tick();
                chk("R12 latched datum", dout, exp_stat(er, src, tg, 1'b0));
            end
            chk("R11 unused bits", dout & 16'hFF1F, 16'h0000);
            seq_busy = 1'b0;
            tick();
            chk("R5 completion array", dout, array_word);
            do_read();
            chk("R5 read after done", dout, array_word);
            tick();
        end

        // R1: toggle restarts from 0 at a new operation
        start_op(1'b0, 1'b1);
        chk("R1 toggle cleared at start", dout, exp_stat(0, 1, 0, 0));
        // R8: reset command ignored while busy
        rst_cmd = 1'b1; tick(); rst_cmd = 1'b0; tick();
        chk("R8 cmd ignored busy", dout, exp_stat(0, 1, 0, 0));
        seq_busy = 1'b0; tick();

        // R6: timeout
        array_word = 16'hBEEF;
        start_op(1'b1, 1'b0);
        repeat (TMO + 2) tick();
        chk("R6 timeout bit", dout, exp_stat(1, 0, 0, 1));
        seq_busy = 1'b0; tick();
        chk("R6 status held after busy drop", dout, exp_stat(1, 0, 0, 1));
        do_read();
        chk("R6 toggle after timeout", dout, exp_stat(1, 0, 1, 1));
        // R7: new start ignored in timeout
        start_op(1'b0, 1'b0);
        seq_busy = 1'b0; tick();
        chk("R7 start ignored", dout, exp_stat(1, 0, 1, 1));
        rst_cmd = 1'b1; tick(); rst_cmd = 1'b0;
        chk("R7 cleared by cmd", dout, 16'hBEEF);

        // R9: hardware reset aborts
        start_op(1'b0, 1'b0);
        chk("R9 busy before abort", dout, exp_stat(0, 0, 0, 0));
        rst = 1'b1; seq_busy = 1'b0; tick(); rst = 1'b0;
        chk("R9 abort to array", dout, 16'hBEEF);

        // R10: protected-only erase window
        tick();
        erase_void = 1'b1; tick(); erase_void = 1'b0;
        chk("R10 window start", dout, exp_stat(1, 0, 0, 0));
        repeat (HOLD - 1) tick();
        chk("R10 window last cycle", dout, exp_stat(1, 0, 0, 0));
        tick();
        chk("R10 window ended", dout, 16'hBEEF);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule